// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block sits in the front end of a superscalar core. Instructions are dispatched in groups of a fixed number of slots. For each candidate instruction the block decides whether the candidate may join the group being filled or must open a new group. The candidate arrives as a class code with a valid flag. The block answers with a combinational `hazard` flag in the same cycle. When the front end dispatches the candidate it pulses `issue`, and the block then charges the candidate against the running group.

Per group the block keeps:
- a count of fixed-point operations, a count of memory operations and a count of floating-point operations;
- one occupancy flag for each of the four units that may be used only once per group;
- the number of slots already filled.

A branch may only take the last slot, and issuing a branch closes the group. A few classes must lead a group. The front end may close a group itself with `group_end`. An issue made while `hazard` is high is read as "open a new group with this instruction".

`hazard` is the only back-pressure this block gives. While it is high, the candidate is refused for the current group. The front end either holds the candidate back or issues it anyway, and issuing it opens a new group. The block stalls nothing by itself.

Top module: `dgh_checker`

## Requirements
- R1: Class codes are 0 fixed-point, 1 fixed-point that must lead, 2 load, 3 store, 4 floating-point, 5 condition-register, 6 special-register, 7 vector arithmetic, 8 vector permute and 9 branch. A valid candidate with code 10 to 15 always raises `hazard`. Issuing such a code starts an empty group and adds nothing to it.
- R2: With `cand_valid` low, `hazard` is low. `hazard` follows the candidate and the group state in the same cycle, with no register in between.
- R3: A group takes at most two fixed-point operations, counting codes 0 and 1 together. A third one raises `hazard`.
- R4: A group takes at most two memory operations, counting loads and stores together. A third one raises `hazard`.
- R5: A group takes at most two floating-point operations.
- R6: Codes 5, 6, 7 and 8 may each be accepted at most once per group. A repeat of any of them raises `hazard`.
- R7: Codes 1, 5 and 6 raise `hazard` unless the group has no filled slot.
- R8: Once four non-branch instructions fill a group, any non-branch candidate raises `hazard`, while a branch is still accepted.
- R9: An accepted branch closes the group, so that every later candidate raises `hazard` until a new group starts. A branch may also be the first instruction of a group.
- R10: `group_end` clears all counts, flags and the slot count at the next clock edge. If `issue` comes in the same cycle with a valid known code, that candidate becomes the first instruction of the new group.
- R11: An `issue` while `hazard` is high starts a new group, and the candidate is its first instruction.
- R12: An `issue` with `cand_valid` low, no hazard and no `group_end` leaves the group state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; opens an empty group |
| cand_valid | input | 1 | A candidate instruction is presented |
| cand_class | input | 4 | Class code of the candidate (R1 encoding) |
| issue | input | 1 | The candidate is dispatched this cycle |
| group_end | input | 1 | Close the current group at this edge |
| hazard | output | 1 | Candidate cannot join the current group |

## Verification
All of the state is internal, so a wrong count, flag or slot number shows up only as a wrong `hazard` on a later candidate. The bench therefore fills groups in chosen orders and probes the boundary candidates within the same cycle. A counter that is stuck or off by one shows up at the third instruction of a class, or at the fifth slot. A flag or slot number that is not cleared shows up as a false hazard on the first candidate after `group_end`, after an issue under hazard, or after a rejected code. A lead-only class probed right after such an event shows a stale slot count within one cycle.

// File: rtl/dgh_pkg.sv
package dgh_pkg;

  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_FIX      = 4'd0,
    CL_FIX_LEAD = 4'd1,
    CL_LOAD     = 4'd2,
    CL_STORE    = 4'd3,
    CL_FLT      = 4'd4,
    CL_CREG     = 4'd5,
    CL_SREG     = 4'd6,
    CL_VARITH   = 4'd7,
    CL_VPERM    = 4'd8,
    CL_BRANCH   = 4'd9
  } iclass_e;

  // single-use units, one occupancy flag each
  localparam int ONCE_N    = 4;
  localparam int ONCE_CREG = 0;
  localparam int ONCE_SREG = 1;
  localparam int ONCE_VAR  = 2;
  localparam int ONCE_VPRM = 3;

  typedef struct packed {
    logic              known;   // code is one of the defined classes
    logic              fix;     // counts toward fixed-point limit
    logic              lead;    // must take the first slot
    logic              mem;     // counts toward memory limit
    logic              flt;     // counts toward floating-point limit
    logic [ONCE_N-1:0] once;    // which single-use unit it occupies
    logic              branch;  // final-slot class, closes the group
  } class_dec_t;

endpackage

// File: rtl/dgh_decode.sv
module dgh_decode
  import dgh_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  output class_dec_t         dec
);

  always_comb begin
    dec = '0;
    dec.known = 1'b1;
    unique case (cls)
      CL_FIX:      dec.fix = 1'b1;
      CL_FIX_LEAD: begin
        dec.fix  = 1'b1;
        dec.lead = 1'b1;
      end
      CL_LOAD,
      CL_STORE:    dec.mem = 1'b1;
      CL_FLT:      dec.flt = 1'b1;
      CL_CREG: begin
        dec.once[ONCE_CREG] = 1'b1;
        dec.lead            = 1'b1;
      end
      CL_SREG: begin
        dec.once[ONCE_SREG] = 1'b1;
        dec.lead            = 1'b1;
      end
      CL_VARITH:   dec.once[ONCE_VAR]  = 1'b1;
      CL_VPERM:    dec.once[ONCE_VPRM] = 1'b1;
      CL_BRANCH:   dec.branch = 1'b1;
      default:     dec.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/dgh_eval.sv
module dgh_eval
  import dgh_pkg::*;
#(
  parameter int MAX_FIX = 2,
  parameter int MAX_MEM = 2,
  parameter int MAX_FLT = 2,
  parameter int SLOTS   = 5,
  localparam int FIX_W  = $clog2(MAX_FIX + 1),
  localparam int MEM_W  = $clog2(MAX_MEM + 1),
  localparam int FLT_W  = $clog2(MAX_FLT + 1),
  localparam int SLOT_W = $clog2(SLOTS + 1)
)(
  input  logic              valid,
  input  class_dec_t        dec,
  input  logic [FIX_W-1:0]  fix_cnt,
  input  logic [MEM_W-1:0]  mem_cnt,
  input  logic [FLT_W-1:0]  flt_cnt,
  input  logic [ONCE_N-1:0] once_used,
  input  logic [SLOT_W-1:0] slot_cnt,
  output logic              hazard
);

  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  typedef enum int {
    WHY_UNKNOWN, WHY_CLOSED, WHY_LASTSLOT, WHY_LEAD,
    WHY_FIX, WHY_MEM, WHY_FLT, WHY_ONCE, WHY_N
  } why_e;

  logic [WHY_N-1:0] why;

  always_comb begin
    why               = '0;
    why[WHY_UNKNOWN]  = !dec.known;
    why[WHY_CLOSED]   = (slot_cnt >= SLOT_END);
    why[WHY_LASTSLOT] = (slot_cnt >= SLOT_LAST) && !dec.branch;
    why[WHY_LEAD]     = dec.lead && (slot_cnt != '0);
    why[WHY_FIX]      = dec.fix && (fix_cnt >= FIX_W'(MAX_FIX));
    why[WHY_MEM]      = dec.mem && (mem_cnt >= MEM_W'(MAX_MEM));
    why[WHY_FLT]      = dec.flt && (flt_cnt >= FLT_W'(MAX_FLT));
    why[WHY_ONCE]     = |(dec.once & once_used);
  end

  assign hazard = valid && (|why);

endmodule

// File: rtl/dgh_state.sv
module dgh_state
  import dgh_pkg::*;
#(
  parameter int MAX_FIX = 2,
  parameter int MAX_MEM = 2,
  parameter int MAX_FLT = 2,
  parameter int SLOTS   = 5,
  localparam int FIX_W  = $clog2(MAX_FIX + 1),
  localparam int MEM_W  = $clog2(MAX_MEM + 1),
  localparam int FLT_W  = $clog2(MAX_FLT + 1),
  localparam int SLOT_W = $clog2(SLOTS + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              group_end,
  input  logic              valid,
  input  logic              hazard,
  input  class_dec_t        dec,
  output logic [FIX_W-1:0]  fix_cnt,
  output logic [MEM_W-1:0]  mem_cnt,
  output logic [FLT_W-1:0]  flt_cnt,
  output logic [ONCE_N-1:0] once_used,
  output logic [SLOT_W-1:0] slot_cnt
);

  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOTS);

  logic clear, take;
  logic [FIX_W-1:0]  fix_base, fix_nxt;
  logic [MEM_W-1:0]  mem_base, mem_nxt;
  logic [FLT_W-1:0]  flt_base, flt_nxt;
  logic [SLOT_W-1:0] slot_base, slot_nxt;

  // new group first, then the candidate is charged against it
  assign clear = group_end || (issue && hazard);
  assign take  = issue && valid && dec.known;

  always_comb begin
    fix_base  = clear ? '0 : fix_cnt;
    mem_base  = clear ? '0 : mem_cnt;
    flt_base  = clear ? '0 : flt_cnt;
    slot_base = clear ? '0 : slot_cnt;

    fix_nxt  = fix_base  + FIX_W'(take && dec.fix);
    mem_nxt  = mem_base  + MEM_W'(take && dec.mem);
    flt_nxt  = flt_base  + FLT_W'(take && dec.flt);
    if (take && dec.branch)
      slot_nxt = SLOT_END;
    else
      slot_nxt = slot_base + SLOT_W'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_cnt  <= '0;
      mem_cnt  <= '0;
      flt_cnt  <= '0;
      slot_cnt <= '0;
    end else begin
      fix_cnt  <= fix_nxt;
      mem_cnt  <= mem_nxt;
      flt_cnt  <= flt_nxt;
      slot_cnt <= slot_nxt;
    end
  end

  for (genvar u = 0; u < ONCE_N; u++) begin : g_once
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        once_used[u] <= 1'b0;
      else
        once_used[u] <= (once_used[u] && !clear) || (take && dec.once[u]);
    end
  end

  // R3 R4 R5: unit counts stay within their limits
  a_r3_fix_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fix_cnt <= FIX_W'(MAX_FIX));
  a_r4_mem_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= MEM_W'(MAX_MEM));
  a_r5_flt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    flt_cnt <= FLT_W'(MAX_FLT));
  // R8: slot count never passes the closed value
  a_r8_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= SLOT_END);
  // R9: an issued branch leaves the group closed
  a_r9_branch_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && valid && dec.known && dec.branch) |=> slot_cnt == SLOT_END);
  // R10: group end without issue empties everything
  a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (group_end && !issue) |=> (slot_cnt == '0 && fix_cnt == '0 &&
                               mem_cnt == '0 && flt_cnt == '0 && once_used == '0));
  // R12: an issue with no candidate changes nothing
  a_r12_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !valid && !group_end) |=> ($stable(slot_cnt) && $stable(fix_cnt) &&
      $stable(mem_cnt) && $stable(flt_cnt) && $stable(once_used)));

endmodule

// File: rtl/dgh_checker.sv
module dgh_checker
  import dgh_pkg::*;
#(
  parameter int MAX_FIX = 2,
  parameter int MAX_MEM = 2,
  parameter int MAX_FLT = 2,
  parameter int SLOTS   = 5,
  localparam int FIX_W  = $clog2(MAX_FIX + 1),
  localparam int MEM_W  = $clog2(MAX_MEM + 1),
  localparam int FLT_W  = $clog2(MAX_FLT + 1),
  localparam int SLOT_W = $clog2(SLOTS + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cand_valid,
  input  logic [CLASS_W-1:0] cand_class,
  input  logic               issue,
  input  logic               group_end,
  output logic               hazard
);

  class_dec_t        dec;
  logic [FIX_W-1:0]  fix_cnt;
  logic [MEM_W-1:0]  mem_cnt;
  logic [FLT_W-1:0]  flt_cnt;
  logic [ONCE_N-1:0] once_used;
  logic [SLOT_W-1:0] slot_cnt;

  dgh_decode u_dec (
    .cls (cand_class),
    .dec (dec)
  );

  dgh_eval #(
    .MAX_FIX(MAX_FIX), .MAX_MEM(MAX_MEM), .MAX_FLT(MAX_FLT), .SLOTS(SLOTS)
  ) u_eval (
    .valid     (cand_valid),
    .dec       (dec),
    .fix_cnt   (fix_cnt),
    .mem_cnt   (mem_cnt),
    .flt_cnt   (flt_cnt),
    .once_used (once_used),
    .slot_cnt  (slot_cnt),
    .hazard    (hazard)
  );

  dgh_state #(
    .MAX_FIX(MAX_FIX), .MAX_MEM(MAX_MEM), .MAX_FLT(MAX_FLT), .SLOTS(SLOTS)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .group_end (group_end),
    .valid     (cand_valid),
    .hazard    (hazard),
    .dec       (dec),
    .fix_cnt   (fix_cnt),
    .mem_cnt   (mem_cnt),
    .flt_cnt   (flt_cnt),
    .once_used (once_used),
    .slot_cnt  (slot_cnt)
  );

  // R2: no candidate, no hazard
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> !hazard);
  // R1: undefined codes are always refused
  a_r1_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_class > CLASS_W'(CL_BRANCH)) |-> hazard);
  // R7: a lead-only class joins an ongoing group only when it is empty
  a_r7_lead_first: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cand_valid && !hazard && !group_end &&
     (cand_class == CL_FIX_LEAD || cand_class == CL_CREG || cand_class == CL_SREG))
    |-> slot_cnt == '0);
  // R11: issue under hazard starts a group holding one instruction
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && hazard && cand_valid && cand_class != CL_BRANCH &&
     cand_class <= CLASS_W'(CL_BRANCH)) |=> slot_cnt == SLOT_W'(1));

endmodule

// File: tb/sim_dgh_checker.sv
`timescale 1ns/1ps
module sim_dgh_checker;

  localparam logic [3:0] FX = 4'd0, LD1 = 4'd1, LD = 4'd2, ST = 4'd3, FP = 4'd4,
                         CR = 4'd5, SR = 4'd6, VA = 4'd7, VP = 4'd8, BR = 4'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cand_valid = 1'b0;
  logic [3:0] cand_class = '0;
  logic issue = 1'b0;
  logic group_end = 1'b0;
  logic hazard;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dgh_checker u0 (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_class(cand_class),
    .issue(issue), .group_end(group_end), .hazard(hazard)
  );

  // driver: set inputs between edges, push the expected hazard
  task automatic step(input logic [3:0] c, input bit v, input bit is, input bit ge,
                      input bit chk, input bit exp, input string tag);
    @(negedge clk);
    cand_class = c; cand_valid = v; issue = is; group_end = ge;
    if (chk) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  task automatic probe(input logic [3:0] c, input bit exp, input string tag);
    step(c, 1'b1, 1'b0, 1'b0, 1'b1, exp, tag);
  endtask

  task automatic put(input logic [3:0] c, input bit exp, input string tag);
    step(c, 1'b1, 1'b1, 1'b0, 1'b1, exp, tag);
  endtask

  task automatic fresh();
    step(FX, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "");
  endtask

  // monitor: compare hazard shortly after inputs settle
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (hazard !== e) begin
        errors++;
        $display("FAIL %s: hazard=%0b expected=%0b", t, hazard, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state: empty group, lead class accepted
    probe(LD1, 1'b0, "R7 reset empty group");
    step(FX, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 no valid no hazard");
    step(CR, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 no valid lead class");

    // R3 fixed-point limit, lead class counted
    fresh();
    put(LD1, 1'b0, "R3 lead first");
    put(FX,  1'b0, "R3 second fx");
    probe(FX, 1'b1, "R3 third fx");
    probe(LD, 1'b0, "R3 other unit free");

    // R4 memory limit
    fresh();
    put(LD, 1'b0, "R4 load");
    put(ST, 1'b0, "R4 store");
    probe(LD, 1'b1, "R4 third load");
    probe(ST, 1'b1, "R4 third store");

    // R5 float limit
    fresh();
    put(FP, 1'b0, "R5 fp1");
    put(FP, 1'b0, "R5 fp2");
    probe(FP, 1'b1, "R5 fp3");

    // R6 once-per-group units
    fresh();
    put(CR, 1'b0, "R6 cr first");
    put(VA, 1'b0, "R6 varith");
    put(VP, 1'b0, "R6 vperm");
    probe(VA, 1'b1, "R6 varith repeat");
    probe(VP, 1'b1, "R6 vperm repeat");
    fresh();
    put(SR, 1'b0, "R6 sreg first");
    probe(SR, 1'b1, "R6 sreg repeat");

    // R7 lead-only classes need an empty group
    fresh();
    put(FX, 1'b0, "R7 fx opens");
    probe(CR,  1'b1, "R7 cr not first");
    probe(SR,  1'b1, "R7 sreg not first");
    probe(LD1, 1'b1, "R7 lead fx not first");
    probe(FX,  1'b0, "R7 plain fx ok");

    // R8 four slots then only branch; R9 branch closes
    fresh();
    put(FX, 1'b0, "R8 s1");
    put(LD, 1'b0, "R8 s2");
    put(FP, 1'b0, "R8 s3");
    put(VA, 1'b0, "R8 s4");
    probe(FX, 1'b1, "R8 fifth non-branch");
    probe(ST, 1'b1, "R8 fifth store");
    probe(BR, 1'b0, "R8 branch in last slot");
    put(BR, 1'b0, "R9 branch issued");
    probe(BR, 1'b1, "R9 closed to branch");
    probe(FX, 1'b1, "R9 closed to fx");
    probe(VP, 1'b1, "R9 closed to vperm");

    // R11 issue under hazard opens a new group with the candidate first
    put(FX, 1'b1, "R11 issue while hazard");
    probe(CR, 1'b1, "R11 candidate holds slot 1");
    probe(FX, 1'b0, "R11 fx count is one");
    put(FX, 1'b0, "R11 second fx");
    probe(FX, 1'b1, "R11 fx limit reached");

    // R10 group end together with issue
    step(CR, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R10 hazard from old group");
    probe(CR, 1'b1, "R10 cr taken into new group");
    probe(SR, 1'b1, "R10 new group not empty");
    probe(FX, 1'b0, "R10 old fx count cleared");
    step(FX, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "");
    probe(CR, 1'b0, "R10 end alone empties group");

    // R9 branch first in a group
    put(BR, 1'b0, "R9 branch opens group");
    probe(FX, 1'b1, "R9 closed after lone branch");

    // R1 undefined codes
    fresh();
    probe(4'd12, 1'b1, "R1 code 12 refused");
    probe(4'd15, 1'b1, "R1 code 15 refused");
    probe(4'd10, 1'b1, "R1 code 10 refused");
    put(FX, 1'b0, "R1 setup fx");
    put(4'd11, 1'b1, "R1 issue undefined");
    probe(LD1, 1'b0, "R1 undefined not counted");

    // R12 issue with no candidate
    fresh();
    step(FX, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R12 idle issue");
    probe(CR, 1'b0, "R12 group still empty");

    step(FX, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule